// File: doc/BRIEF.md
# Real-Mode Segmented Memory Access Unit

This block turns segment-plus-offset memory requests, as a 16-bit real-mode processor core issues them, into physical byte cycles on a byte-wide synchronous memory port with a 20-bit address. It keeps four 16-bit segment registers, which are the extra, code, stack and data segments. Beside each register it caches the 20-bit base that register implies. It also holds the instruction pointer and its reset value.

Requests are byte or word reads, writes or read-modify-writes. The unit splits a word into two byte cycles, always in the order low byte first. It handles both ways a word can wrap: past the end of its segment, and past the top of the physical space. A read-modify-write returns the bytes it read. It then waits for the updated value and writes it back to exactly the addresses it read.

A request is a one-cycle pulse taken only while the unit is idle. Completion is a one-cycle `done` pulse that carries the read data.

Top module: `seg_mem_unit`

## Requirements
- R1: After reset the code segment holds 0xFFFF and the other three segment registers hold 0. The instruction pointer is 0, and `busy`, `done`, `rmw_wait` and `mem_we` are low. A code-segment access at offset 0 therefore reaches physical 0xFFFF0.
- R2: Loading a segment register (`seg_ld`, with `seg_ld_sel` 0 = extra, 1 = code, 2 = stack, 3 = data) updates its cached base to the value shifted left by four bits. Every request accepted afterwards uses the new base.
- R3: The low-byte physical address is (base + offset) modulo 2^20.
- R4: `req_seg` picks the extra segment with 0, the code segment with 1 and the stack segment with 2. Every other value (3 to 7) picks the data segment.
- R5: Words are little-endian. Bits 7:0 go to or come from the low-byte address, and bits 15:8 to or from the next address. The low-byte memory cycle is always issued before the high-byte cycle.
- R6: For a word at offset 0xFFFF, the high byte is at offset 0x0000 of the same segment, that is, at the segment base.
- R7: For a word whose low byte falls at physical 0xFFFFF, with an offset other than 0xFFFF, the high byte is at physical 0x00000.
- R8: A byte write issues exactly one memory write cycle, carrying `req_wdata[7:0]`. A byte read returns the byte in `rdata[7:0]`, with `rdata[15:8]` zero.
- R9: A read-modify-write (`req_kind` = 2) reads its one or two bytes and then raises `rmw_wait`, with the read value on `rdata`. It holds there with no memory writes until `wb_valid`. It then writes `wb_data` to the same addresses it read, low byte first, and then pulses `done`. `req_kind` 0 and 3 are reads, and 1 is a write.
- R10: `done` is a single-cycle pulse, raised while `busy` is high, and it comes once per accepted request. `req_valid` has no effect while `busy` is high. Latency from the accepting edge to `done` is 2 cycles for a byte write, 3 for a byte read or word write, and 4 for a word read.
- R11: Asserting `ip_ld` loads `ip_val` into the instruction pointer, which is visible on `ip_out` after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_ld | input | 1 | Load a segment register |
| seg_ld_sel | input | 2 | Segment register to load (0 extra, 1 code, 2 stack, 3 data) |
| seg_ld_val | input | 16 | Value to load |
| ip_ld | input | 1 | Load the instruction pointer |
| ip_val | input | 16 | Instruction pointer load value |
| ip_out | output | 16 | Instruction pointer |
| req_valid | input | 1 | Request pulse, taken when not busy |
| req_seg | input | 3 | Segment select |
| req_off | input | 16 | Offset within segment |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_kind | input | 2 | 0/3 read, 1 write, 2 read-modify-write |
| req_wdata | input | 16 | Write data |
| wb_valid | input | 1 | Updated value ready for read-modify-write |
| wb_data | input | 16 | Updated value |
| busy | output | 1 | Request in progress |
| rmw_wait | output | 1 | Read-modify-write waiting for `wb_valid` |
| done | output | 1 | Completion pulse |
| rdata | output | 16 | Read data |
| mem_addr | output | 20 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after its address |

## Verification
The bench aims at the two wrap cases: a word at segment offset 0xFFFF, and a word whose low byte lands on 0xFFFFF. A design that simply incremented the linear address would fetch or overwrite the byte just past the segment, or a byte outside 20 bits. Read-modify-write is checked on both wrap cases. A unit that recomputed the write-back addresses, or wrote the high byte first, would corrupt a neighbouring byte or break the ordering the write monitor expects. Selector values above 2, a segment reload, the code-segment reset value, and a request raised while busy are also driven. A stale base, a missing data-segment default or a second accepted request would each show up as a wrong address or as an unexpected `done` or write.

// File: rtl/smu_pkg.sv
package smu_pkg;
  parameter int unsigned SMU_SW = 16;            // segment / offset width
  parameter int unsigned SMU_AW = 20;            // physical address width
  parameter int unsigned SMU_BW = 8;             // memory byte width
  parameter int unsigned SMU_NSEG = 4;           // number of segment registers
  localparam int unsigned SMU_SHIFT = SMU_AW - SMU_SW;

  // Slot order shared by loads and requests
  localparam int unsigned SLOT_ES = 0;
  localparam int unsigned SLOT_CS = 1;
  localparam int unsigned SLOT_SS = 2;
  localparam int unsigned SLOT_DS = 3;

  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_RMW   = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_RD_HI, ST_RD_WAIT, ST_HOLD, ST_WR_LO, ST_WR_HI, ST_FIN
  } seq_state_e;

  function automatic logic [SMU_AW-1:0] base_of(input logic [SMU_SW-1:0] seg);
    return {seg, {SMU_SHIFT{1'b0}}};
  endfunction

  function automatic logic [SMU_AW-1:0] low_addr(input logic [SMU_AW-1:0] base,
                                                 input logic [SMU_SW-1:0] off);
    return base + {{SMU_SHIFT{1'b0}}, off};
  endfunction

  // High byte: segment start on offset wrap, otherwise next byte mod 2^AW
  function automatic logic [SMU_AW-1:0] high_addr(input logic [SMU_AW-1:0] base,
                                                  input logic [SMU_SW-1:0] off,
                                                  input logic [SMU_AW-1:0] lo);
    if (off == {SMU_SW{1'b1}}) return base;
    return lo + {{(SMU_AW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [1:0] slot_of(input logic [2:0] sel);
    if (sel == 3'd0) return 2'(SLOT_ES);
    if (sel == 3'd1) return 2'(SLOT_CS);
    if (sel == 3'd2) return 2'(SLOT_SS);
    return 2'(SLOT_DS);
  endfunction
endpackage

// File: rtl/smu_seg_slot.sv
module smu_seg_slot #(
  parameter int unsigned SW = 16,
  parameter int unsigned AW = 20,
  parameter logic [SW-1:0] RESET_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [SW-1:0] ld_val,
  output logic [SW-1:0] seg_q,
  output logic [AW-1:0] base_q
);
  localparam int unsigned SH = AW - SW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q  <= RESET_VAL;
      base_q <= {RESET_VAL, {SH{1'b0}}};
    end else if (ld) begin
      seg_q  <= ld_val;
      base_q <= {ld_val, {SH{1'b0}}};
    end
  end
endmodule

// File: rtl/smu_addr_gen.sv
module smu_addr_gen
  import smu_pkg::*;
#(
  parameter int unsigned SW = SMU_SW,
  parameter int unsigned AW = SMU_AW,
  parameter int unsigned NSEG = SMU_NSEG
) (
  input  logic [NSEG-1:0][AW-1:0] bases,
  input  logic [2:0]              sel,
  input  logic [SW-1:0]           off,
  output logic [AW-1:0]           sel_base,
  output logic [AW-1:0]           lo,
  output logic [AW-1:0]           hi
);
  always_comb begin
    sel_base = bases[slot_of(sel)];
    lo       = low_addr(sel_base, off);
    hi       = high_addr(sel_base, off, lo);
  end
endmodule

// File: rtl/smu_access_seq.sv
module smu_access_seq
  import smu_pkg::*;
#(
  parameter int unsigned AW = SMU_AW,
  parameter int unsigned BW = SMU_BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_word,
  input  logic [1:0]      req_kind,
  input  logic [2*BW-1:0] req_wdata,
  input  logic [AW-1:0]   lo,
  input  logic [AW-1:0]   hi,
  input  logic            wb_valid,
  input  logic [2*BW-1:0] wb_data,
  input  logic [BW-1:0]   mem_rdata,
  output logic            acc_fire,
  output logic            busy,
  output logic            done,
  output logic            rmw_wait,
  output logic [2*BW-1:0] rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic [BW-1:0]   mem_wdata
);
  localparam int unsigned DW = 2 * BW;

  seq_state_e st;
  logic [AW-1:0] lo_q, hi_q;
  logic          word_q, rmw_q;
  logic [DW-1:0] wd_q, rd_q;

  assign acc_fire = (st == ST_IDLE) && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      lo_q   <= '0;
      hi_q   <= '0;
      word_q <= 1'b0;
      rmw_q  <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          lo_q   <= lo;
          hi_q   <= hi;
          word_q <= req_word;
          rmw_q  <= (req_kind == KIND_RMW);
          wd_q   <= req_wdata;
          st     <= (req_kind == KIND_WRITE) ? ST_WR_LO : ST_RD_LO;
        end
        ST_RD_LO:   st <= word_q ? ST_RD_HI : ST_RD_WAIT;
        ST_RD_HI: begin
          rd_q[BW-1:0] <= mem_rdata;
          st           <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (word_q) rd_q[DW-1:BW] <= mem_rdata;
          else        rd_q          <= {{BW{1'b0}}, mem_rdata};
          st <= rmw_q ? ST_HOLD : ST_FIN;
        end
        ST_HOLD: if (wb_valid) begin
          wd_q <= wb_data;
          st   <= ST_WR_LO;
        end
        ST_WR_LO:   st <= word_q ? ST_WR_HI : ST_FIN;
        ST_WR_HI:   st <= ST_FIN;
        ST_FIN:     st <= ST_IDLE;
        default:    st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st != ST_IDLE);
    done      = (st == ST_FIN);
    rmw_wait  = (st == ST_HOLD);
    rdata     = rd_q;
    mem_we    = (st == ST_WR_LO) || (st == ST_WR_HI);
    mem_addr  = ((st == ST_RD_HI) || (st == ST_WR_HI)) ? hi_q : lo_q;
    mem_wdata = (st == ST_WR_HI) ? wd_q[DW-1:BW] : wd_q[BW-1:0];
  end
endmodule

// File: rtl/seg_mem_unit.sv
module seg_mem_unit
  import smu_pkg::*;
#(
  parameter int unsigned SW = SMU_SW,
  parameter int unsigned AW = SMU_AW,
  parameter int unsigned BW = SMU_BW,
  parameter logic [SW-1:0] CS_RESET = '1,
  parameter logic [SW-1:0] IP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seg_ld,
  input  logic [1:0]      seg_ld_sel,
  input  logic [SW-1:0]   seg_ld_val,
  input  logic            ip_ld,
  input  logic [SW-1:0]   ip_val,
  output logic [SW-1:0]   ip_out,
  input  logic            req_valid,
  input  logic [2:0]      req_seg,
  input  logic [SW-1:0]   req_off,
  input  logic            req_word,
  input  logic [1:0]      req_kind,
  input  logic [2*BW-1:0] req_wdata,
  input  logic            wb_valid,
  input  logic [2*BW-1:0] wb_data,
  output logic            busy,
  output logic            rmw_wait,
  output logic            done,
  output logic [2*BW-1:0] rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic [BW-1:0]   mem_wdata,
  input  logic [BW-1:0]   mem_rdata
);
  localparam int unsigned NSEG = SMU_NSEG;

  logic [NSEG-1:0][AW-1:0] bases;
  logic [NSEG-1:0][SW-1:0] segs;
  logic [AW-1:0]           sel_base, calc_lo, calc_hi;
  logic                    acc_fire;

  for (genvar g = 0; g < NSEG; g++) begin : g_slot
    localparam logic [SW-1:0] RV = (g == SLOT_CS) ? CS_RESET : '0;
    smu_seg_slot #(.SW(SW), .AW(AW), .RESET_VAL(RV)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (seg_ld && (seg_ld_sel == 2'(g))),
      .ld_val (seg_ld_val),
      .seg_q  (segs[g]),
      .base_q (bases[g])
    );
  end

  smu_addr_gen #(.SW(SW), .AW(AW), .NSEG(NSEG)) u_agen (
    .bases    (bases),
    .sel      (req_seg),
    .off      (req_off),
    .sel_base (sel_base),
    .lo       (calc_lo),
    .hi       (calc_hi)
  );

  smu_access_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_word  (req_word),
    .req_kind  (req_kind),
    .req_wdata (req_wdata),
    .lo        (calc_lo),
    .hi        (calc_hi),
    .wb_valid  (wb_valid),
    .wb_data   (wb_data),
    .mem_rdata (mem_rdata),
    .acc_fire  (acc_fire),
    .busy      (busy),
    .done      (done),
    .rmw_wait  (rmw_wait),
    .rdata     (rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     ip_out <= IP_RESET;
    else if (ip_ld) ip_out <= ip_val;
  end

  logic unused_segs;
  assign unused_segs = ^segs;
endmodule

// File: rtl/smu_checker.sv
module smu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_fire,
  input logic        req_word,
  input logic [1:0]  req_kind,
  input logic [15:0] req_off,
  input logic [15:0] req_wdata,
  input logic [19:0] sel_base,
  input logic [19:0] calc_lo,
  input logic        busy,
  input logic        done,
  input logic        rmw_wait,
  input logic        wb_valid,
  input logic [19:0] mem_addr,
  input logic        mem_we,
  input logic [7:0]  mem_wdata
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);
  a_r5_low_first: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && req_word && req_kind == 2'd1) |=>
      (mem_we && mem_addr == $past(calc_lo) && mem_wdata == $past(req_wdata[7:0])));
  a_r6_seg_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && req_word && req_kind == 2'd1 && req_off == 16'hFFFF) |=>
      ##1 (mem_we && mem_addr == $past(sel_base, 2)));
  a_r7_phys_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && req_word && req_kind == 2'd1 && req_off != 16'hFFFF &&
     calc_lo == 20'hFFFFF) |=> ##1 (mem_we && mem_addr == 20'h00000));
  a_r8_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !req_word && req_kind == 2'd1) |=> mem_we ##1 !mem_we);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_wait && !wb_valid) |=> (rmw_wait && !mem_we));
endmodule

bind seg_mem_unit smu_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_fire  (acc_fire),
  .req_word  (req_word),
  .req_kind  (req_kind),
  .req_off   (req_off),
  .req_wdata (req_wdata),
  .sel_base  (sel_base),
  .calc_lo   (calc_lo),
  .busy      (busy),
  .done      (done),
  .rmw_wait  (rmw_wait),
  .wb_valid  (wb_valid),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata)
);

// File: tb/seg_mem_unit_bench.sv
module seg_mem_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        seg_ld = 0;
  logic [1:0]  seg_ld_sel = 0;
  logic [15:0] seg_ld_val = 0;
  logic        ip_ld = 0;
  logic [15:0] ip_val = 0;
  logic [15:0] ip_out;
  logic        req_valid = 0;
  logic [2:0]  req_seg = 0;
  logic [15:0] req_off = 0;
  logic        req_word = 0;
  logic [1:0]  req_kind = 0;
  logic [15:0] req_wdata = 0;
  logic        wb_valid = 0;
  logic [15:0] wb_data = 0;
  logic        busy, rmw_wait, done, mem_we;
  logic [15:0] rdata;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 0;

  seg_mem_unit u_seg_mem_unit (.*);

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  // Device memory and independent reference memory
  logic [7:0] dev  [logic [19:0]];
  logic [7:0] refm [logic [19:0]];
  logic [15:0] segm [4];

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
  endfunction
  function automatic logic [7:0] dev_rd(input logic [19:0] a);
    return dev.exists(a) ? dev[a] : pat(a);
  endfunction
  function automatic logic [7:0] ref_rd(input logic [19:0] a);
    return refm.exists(a) ? refm[a] : pat(a);
  endfunction

  always @(posedge clk) begin
    if (mem_we) dev[mem_addr] = mem_wdata;
    mem_rdata <= dev_rd(mem_addr);
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard queues
  logic [16:0] exp_rd [$];  // {check_flag, value}
  string       rd_tag [$];
  logic [27:0] exp_wr [$];  // {addr, data}
  string       wr_tag [$];

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_wr.size() == 0) check("R10 unexpected write", {4'h0, mem_addr, mem_wdata}, 32'hFFFFFFFF);
      else begin
        logic [27:0] e;
        string t;
        e = exp_wr.pop_front();
        t = wr_tag.pop_front();
        check(t, {4'h0, mem_addr, mem_wdata}, {4'h0, e});
      end
    end
    if (rst_n && done) begin
      if (exp_rd.size() == 0) check("R10 unexpected done", {16'h0, rdata}, 32'hFFFFFFFF);
      else begin
        logic [16:0] e;
        string t;
        e = exp_rd.pop_front();
        t = rd_tag.pop_front();
        if (e[16]) check(t, {16'h0, rdata}, {16'h0, e[15:0]});
      end
    end
  end

  function automatic int slot(input logic [2:0] s);
    return (s < 3) ? int'(s) : 3;
  endfunction
  function automatic logic [19:0] b_lo(input logic [15:0] s, input logic [15:0] o);
    int unsigned v;
    v = ((int'(s) * 16) + int'(o)) % 1048576;
    return v[19:0];
  endfunction
  function automatic logic [19:0] b_hi(input logic [15:0] s, input logic [15:0] o);
    int unsigned v;
    if (o == 16'hFFFF) v = (int'(s) * 16) % 1048576;
    else v = (int'(b_lo(s, o)) + 1) % 1048576;
    return v[19:0];
  endfunction

  task automatic load_seg(input logic [1:0] idx, input logic [15:0] v);
    @(negedge clk);
    seg_ld = 1; seg_ld_sel = idx; seg_ld_val = v;
    @(negedge clk);
    seg_ld = 0;
    segm[idx] = v;
  endtask

  task automatic issue(input string tag, input logic [2:0] sel, input logic [15:0] off,
                       input logic word, input logic [1:0] kind,
                       input logic [15:0] wd, input logic [15:0] wbd);
    logic [19:0] a0, a1;
    logic [15:0] rv, nv;
    a0 = b_lo(segm[slot(sel)], off);
    a1 = b_hi(segm[slot(sel)], off);
    rv = word ? {ref_rd(a1), ref_rd(a0)} : {8'h00, ref_rd(a0)};
    nv = (kind == 2'd2) ? wbd : wd;
    if (kind == 2'd1 || kind == 2'd2) begin
      exp_wr.push_back({a0, nv[7:0]}); wr_tag.push_back({tag, " low"});
      refm[a0] = nv[7:0];
      if (word) begin
        exp_wr.push_back({a1, nv[15:8]}); wr_tag.push_back({tag, " high"});
        refm[a1] = nv[15:8];
      end
    end
    exp_rd.push_back({(kind != 2'd1), rv}); rd_tag.push_back({tag, " rdata"});
    @(negedge clk);
    req_valid = 1; req_seg = sel; req_off = off; req_word = word;
    req_kind = kind; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (kind == 2'd2) begin
      while (!rmw_wait) @(negedge clk);
      check({tag, " R9 hold rdata"}, {16'h0, rdata}, {16'h0, rv});
      repeat (2) @(negedge clk);
      check({tag, " R9 still waiting"}, {31'h0, rmw_wait}, 32'h1);
      wb_valid = 1; wb_data = wbd;
      @(negedge clk);
      wb_valid = 0;
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    segm[0] = 16'h0000; segm[1] = 16'hFFFF; segm[2] = 16'h0000; segm[3] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ip_out", {16'h0, ip_out}, 32'h0);
    check("R1 busy", {31'h0, busy}, 0);
    check("R1 done", {31'h0, done}, 0);
    check("R1 rmw_wait", {31'h0, rmw_wait}, 0);
    check("R1 mem_we", {31'h0, mem_we}, 0);

    // R1 R3 code segment reset: byte read CS:0000 -> FFFF0
    issue("R1 cs reset byte read", 3'd1, 16'h0000, 0, 2'd0, 0, 0);
    // R7 word read CS:000F -> FFFFF, 00000
    issue("R7 phys wrap read", 3'd1, 16'h000F, 1, 2'd3, 0, 0);
    // R2 R5 load DS and word read
    load_seg(2'd3, 16'h1234);
    issue("R2 R5 ds word read", 3'd3, 16'h0010, 1, 2'd0, 0, 0);
    // R4 selector values above 3 pick data segment
    issue("R4 sel5 to data", 3'd5, 16'h0022, 1, 2'd0, 0, 0);
    issue("R4 sel7 to data", 3'd7, 16'h0100, 0, 2'd0, 0, 0);
    issue("R4 sel0 extra", 3'd0, 16'h0042, 0, 2'd0, 0, 0);
    // R3 sum wraps past 2^20
    issue("R3 sum wrap read", 3'd1, 16'h0020, 1, 2'd0, 0, 0);
    // R6 word write at offset FFFF of stack segment, read back
    load_seg(2'd2, 16'hF000);
    issue("R6 seg wrap write", 3'd2, 16'hFFFF, 1, 2'd1, 16'hC3A7, 0);
    issue("R6 seg wrap readback", 3'd2, 16'hFFFF, 1, 2'd0, 0, 0);
    // R8 byte write then readback
    issue("R8 byte write", 3'd0, 16'h0100, 0, 2'd1, 16'h77A5, 0);
    issue("R8 byte readback", 3'd0, 16'h0100, 1, 2'd0, 0, 0);
    // R7 word write crossing top of physical space
    issue("R7 phys wrap write", 3'd1, 16'h000F, 1, 2'd1, 16'h9A5B, 0);
    issue("R7 phys wrap readback", 3'd1, 16'h000F, 1, 2'd0, 0, 0);
    // R9 read-modify-write cases
    issue("R9 rmw word", 3'd3, 16'h0020, 1, 2'd2, 0, 16'hBEEF);
    issue("R9 rmw readback", 3'd3, 16'h0020, 1, 2'd0, 0, 0);
    issue("R9 R6 rmw seg wrap", 3'd0, 16'hFFFF, 1, 2'd2, 0, 16'h1357);
    issue("R9 rmw byte", 3'd2, 16'h0004, 0, 2'd2, 0, 16'h00D2);
    // R2 reload data segment, new base used
    load_seg(2'd3, 16'h0800);
    issue("R2 reload ds", 3'd3, 16'h0003, 1, 2'd0, 0, 0);

    // R10 request while busy is ignored
    begin
      logic [19:0] a0, a1;
      a0 = b_lo(segm[3], 16'h0040);
      a1 = b_hi(segm[3], 16'h0040);
      exp_rd.push_back({1'b1, ref_rd(a1), ref_rd(a0)});
      rd_tag.push_back("R10 busy ignore rdata");
      @(negedge clk);
      req_valid = 1; req_seg = 3; req_off = 16'h0040; req_word = 1; req_kind = 0;
      @(negedge clk);
      req_kind = 2'd1; req_word = 0; req_wdata = 16'h00EE; req_off = 16'h0041;
      repeat (2) @(negedge clk);
      req_valid = 0;
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      check("R10 busy ignore no stray done", {16'h0, 15'h0, done}, 0);
    end
    // R10 latency: byte write done 2 cycles after accepting edge
    begin
      int cyc;
      exp_wr.push_back({b_lo(segm[0], 16'h0200), 8'h3C}); wr_tag.push_back("R10 lat write");
      refm[b_lo(segm[0], 16'h0200)] = 8'h3C;
      exp_rd.push_back(17'h0); rd_tag.push_back("R10 lat");
      @(negedge clk);
      req_valid = 1; req_seg = 0; req_off = 16'h0200; req_word = 0; req_kind = 1; req_wdata = 16'h003C;
      @(negedge clk);
      req_valid = 0;
      cyc = 1;
      while (!done && cyc < 10) begin @(negedge clk); cyc++; end
      check("R10 byte write latency", cyc, 2);
      while (busy) @(negedge clk);
    end
    // R11 instruction pointer load
    @(negedge clk);
    ip_ld = 1; ip_val = 16'h5AC3;
    @(negedge clk);
    ip_ld = 0;
    check("R11 ip load", {16'h0, ip_out}, 32'h5AC3);

    repeat (3) @(negedge clk);
    check("R10 read queue drained", exp_rd.size(), 0);
    check("R10 write queue drained", exp_wr.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule